// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management side of a PHY link. It turns one packed 32-bit command word into a complete serial management frame on MDC and MDIO. Software first programs a rate field. It then writes the command word, which holds the start code, opcode, PHY address, register address, turnaround code and 16 data bits. The engine sends a 32-bit all-ones preamble. It then shifts the command word out most significant bit first, one bit per MDC period.

For a read, the engine releases the data line for the turnaround and the 16 data bits. It samples the PHY's reply on rising MDC edges and places the reply in the low half of the command register. When the frame ends, a sticky completion flag is raised. Software clears that flag by writing a one to it.

MDC runs only while a frame is in flight. Its half period equals the rate field in system clocks. A rate of zero keeps the engine from starting a frame.

Top module: `mdio_mm_master`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low and MDIO out is high. All three registers read zero: command at address 0, event/status at address 1, rate at address 2.
- R2: The rate field is written and read at bits [6:1] of address 2. While a frame runs, MDC is high for S system clocks and then low for S clocks, where S is the rate field. While idle, MDC stays low.
- R3: A write to address 0 starts a frame only when the engine is idle and the rate field is nonzero. In any other case the write is ignored, and the command register keeps its old contents.
- R4: A frame is 64 bit times. The first 32 bits are ones. The remaining 32 are command bits 31 down to 0. MDIO out changes only together with a falling MDC edge, and the first bit is present from the clock after the accepted write.
- R5: An opcode of 2'b10 in bits [29:28] marks a read. For a read, the output enable is low for the last 18 bit times (turnaround and data). For any other opcode, the output enable is high for the whole frame.
- R6: In a read frame, MDIO in is sampled at the rising MDC edge of each of the last 16 bit times, most significant bit first, into bits [15:0] of the command register. Bits [31:16] are kept. A frame of any other opcode never changes the command register.
- R7: On the clock of the final falling MDC edge of a frame, the event flag (bit 23 of address 1) becomes 1 and the busy bit (bit 0 of address 1) becomes 0.
- R8: Writing address 1 with bit 23 set clears the event flag. Writing it with bit 23 clear leaves the flag unchanged. If a clear and a completion fall in the same clock, the flag ends up set.
- R9: The busy bit reads 1 from the clock after an accepted command write until the frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 command, 1 event/status, 2 rate |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
A wrong bit index or divider count appears at the pins within one MDC period, as a misplaced MDC edge or a wrong MDIO level. This is why MDC, MDIO out and the output enable are compared against a behavioural model on every clock. A wrong read decode shows on the output enable at bit 46 of the frame. A wrong sample position shows only later, when the command register is read back after completion. The bench therefore replies with asymmetric 16-bit patterns at several rates.

Faults in the completion flag cannot be seen on the pins. They show at the register port in the clock after the last falling MDC edge. A clear timed onto that same clock exposes a wrong priority.

// File: rtl/mdio_mm_pkg.sv
package mdio_mm_pkg;
   localparam int unsigned CMD_W = 32;
   localparam int unsigned RD_W  = 16;

   localparam logic [1:0] ADDR_CMD = 2'd0;
   localparam logic [1:0] ADDR_EVT = 2'd1;
   localparam logic [1:0] ADDR_SPD = 2'd2;

   localparam int unsigned EVT_DONE_BIT = 23;
   localparam int unsigned EVT_BUSY_BIT = 0;

   localparam int unsigned OP_HI = 29;
   localparam int unsigned OP_LO = 28;
   localparam logic [1:0]  OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mm_clkgen.sv
module mdio_mm_clkgen #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_p,
   output logic             fall_p
);
   logic [DIV_W-1:0] cnt_q;
   logic             mdc_q;
   logic             run;
   logic             term;

   assign run  = en && (div != '0);
   assign term = (cnt_q == div - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign rise_p = run && term && !mdc_q;
   assign fall_p = run && term &&  mdc_q;
   assign mdc    = mdc_q;

   AST_MDC_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !mdc_q); // R2
endmodule

// File: rtl/mdio_mm_seq.sv
module mdio_mm_seq
   import mdio_mm_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic             rise_p,
   input  logic             fall_p,
   input  logic             mdio_i,
   output logic             busy,
   output logic [CMD_W-1:0] word,
   output logic             mdio_o,
   output logic             mdio_oe,
   output logic             done_p
);
   localparam int unsigned FRAME_LEN = PRE_LEN + CMD_W;
   localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
   localparam int unsigned SEL_W     = $clog2(CMD_W);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
   localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(FRAME_LEN - RD_W - 2);
   localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(FRAME_LEN - RD_W);

   logic [IDX_W-1:0] idx_q;
   logic [CMD_W-1:0] word_q;
   logic             busy_q;
   logic [SEL_W-1:0] sel;
   logic             is_read;
   logic             last;

   assign sel     = SEL_W'(IDX_LAST - idx_q);
   assign is_read = (word_q[OP_HI:OP_LO] == OP_READ);
   assign last    = (idx_q == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         word_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         word_q <= cmd_in;
      end else if (busy_q) begin
         if (rise_p && is_read && (idx_q >= IDX_DAT))
            word_q[sel] <= mdio_i;
         if (fall_p) begin
            if (last) begin
               busy_q <= 1'b0;
               idx_q  <= '0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   assign done_p  = busy_q && fall_p && last;
   assign mdio_o  = (!busy_q || idx_q < IDX_PRE) ? 1'b1 : word_q[sel];
   assign mdio_oe = busy_q && !(is_read && idx_q >= IDX_TA);
   assign busy    = busy_q;
   assign word    = word_q;

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fall_p) |=> $stable(idx_q)); // R4
   AST_WRITE_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !is_read && !start) |=> $stable(word_q)); // R6
endmodule

// File: rtl/mdio_mm_regs.sv
module mdio_mm_regs
   import mdio_mm_pkg::*;
#(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             clr_bit,
   input  logic [DIV_W-1:0] spd_in,
   input  logic             busy,
   input  logic             done_p,
   input  logic [CMD_W-1:0] word,
   output logic             start,
   output logic [DIV_W-1:0] div,
   output logic [31:0]      bus_rdata
);
   logic             evt_q;
   logic [DIV_W-1:0] div_q;
   logic             clr_req;

   assign start   = bus_wr && (bus_addr == ADDR_CMD) && !busy && (div_q != '0);
   assign clr_req = bus_wr && (bus_addr == ADDR_EVT) && clr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= 1'b0;
         div_q <= '0;
      end else begin
         if (done_p)       evt_q <= 1'b1;
         else if (clr_req) evt_q <= 1'b0;
         if (bus_wr && bus_addr == ADDR_SPD) div_q <= spd_in;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_CMD: bus_rdata = word;
         ADDR_EVT: begin
            bus_rdata[EVT_DONE_BIT] = evt_q;
            bus_rdata[EVT_BUSY_BIT] = busy;
         end
         ADDR_SPD: bus_rdata[DIV_W:1] = div_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign div = div_q;

   AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |=> evt_q); // R7
   AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !done_p) |=> !evt_q); // R8
endmodule

// File: rtl/mdio_mm_master.sv
module mdio_mm_master
   import mdio_mm_pkg::*;
#(
   parameter int unsigned DIV_W   = 6,
   parameter int unsigned PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  bus_addr,
   input  logic        bus_wr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (DIV_W < 1 || DIV_W > 30) begin : g_bad_div
         $error("DIV_W must lie in 1..30");
      end
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..64");
      end
   endgenerate

   logic             start;
   logic             busy;
   logic             done_p;
   logic             rise_p;
   logic             fall_p;
   logic [DIV_W-1:0] div;
   logic [CMD_W-1:0] word;

   mdio_mm_regs #(.DIV_W(DIV_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .clr_bit   (bus_wdata[EVT_DONE_BIT]),
      .spd_in    (bus_wdata[DIV_W:1]),
      .busy      (busy),
      .done_p    (done_p),
      .word      (word),
      .start     (start),
      .div       (div),
      .bus_rdata (bus_rdata)
   );

   mdio_mm_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (busy),
      .div    (div),
      .mdc    (mdc),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   mdio_mm_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cmd_in  (bus_wdata),
      .rise_p  (rise_p),
      .fall_p  (fall_p),
      .mdio_i  (mdio_i),
      .busy    (busy),
      .word    (word),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .done_p  (done_p)
   );

   AST_START_NEEDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (div != '0)); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe)); // R2
endmodule

// File: tb/mdio_mm_master_tb_top.sv
module mdio_mm_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #10 clk = ~clk;

   mdio_mm_master dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // behavioural reference state
   int          m_k = 0;
   int          m_spd = 0;
   bit          m_busy = 0;
   bit          m_evt = 0;
   logic [31:0] m_word = 32'd0;
   logic [15:0] reply = 16'd0;
   int          nvec = 0;
   int          nerr = 0;

   function automatic bit m_read();
      return m_word[29:28] == 2'b10;
   endfunction

   function automatic int m_bit();
      return (m_spd == 0) ? 0 : m_k / (2 * m_spd);
   endfunction

   always @(posedge clk) begin : model
      bit was_busy;
      was_busy = m_busy;
      if (!rst_n) begin
         m_k = 0; m_spd = 0; m_busy = 0; m_evt = 0; m_word = 32'd0;
      end else begin
         if (m_busy) begin
            if ((m_k % (2 * m_spd)) == m_spd - 1 && m_read() && m_bit() >= 48)
               m_word[63 - m_bit()] = mdio_i;
            m_k++;
         end
         if (bus_wr && bus_addr == 2'd1 && bus_wdata[23]) m_evt = 0;
         if (m_busy && m_k == 128 * m_spd) begin
            m_busy = 0; m_evt = 1; m_k = 0;
         end
         if (bus_wr && bus_addr == 2'd0 && !was_busy && m_spd != 0) begin
            m_busy = 1; m_k = 0; m_word = bus_wdata;
         end
         if (bus_wr && bus_addr == 2'd2) m_spd = int'(bus_wdata[6:1]);
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // PHY reply driver and per-clock comparison
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (m_busy && m_read() && m_bit() >= 48) mdio_i = reply[63 - m_bit()];
         else mdio_i = 1'b1;
         #2;
         begin : cmp
            bit          e_mdc, e_oe, e_o;
            logic [31:0] e_rd;
            int          b;
            b     = m_bit();
            e_mdc = m_busy && ((m_k % (2 * m_spd)) >= m_spd);
            e_oe  = m_busy && !(m_read() && b >= 46);
            e_o   = (!m_busy || b < 32) ? 1'b1 : m_word[63 - b];
            check(mdc == e_mdc, "R2", "mdc", {31'd0, mdc}, {31'd0, e_mdc});
            check(mdio_oe == e_oe, "R5", "mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            if (e_oe || !m_busy)
               check(mdio_o == e_o, "R4", "mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
            case (bus_addr)
               2'd0:    e_rd = m_word;
               2'd1:    e_rd = {8'd0, m_evt, 22'd0, m_busy};
               2'd2:    e_rd = 32'(m_spd) << 1;
               default: e_rd = 32'd0;
            endcase
            check(bus_rdata == e_rd, (bus_addr == 2'd1) ? "R9" : "R6",
                  "rdata", bus_rdata, e_rd);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic expect_reg(input logic [1:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #3;
      check(bus_rdata == exp, req, "register", bus_rdata, exp);
   endtask

   localparam logic [31:0] CMD_WR  = {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3};
   localparam logic [31:0] CMD_RD1 = {2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0000};
   localparam logic [31:0] CMD_RD3 = {2'b01, 2'b10, 5'd31, 5'd31, 2'b10, 16'hFFFF};
   localparam logic [31:0] EVT     = 32'h0080_0000;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_reg(2'd0, 32'd0, "R1");
      expect_reg(2'd1, 32'd0, "R1");
      expect_reg(2'd2, 32'd0, "R1");
      // R3 zero rate blocks the start
      wr(2'd0, CMD_WR);
      expect_reg(2'd0, 32'd0, "R3");
      expect_reg(2'd1, 32'd0, "R3");
      // R2 rate field
      wr(2'd2, 32'd2 << 1);
      expect_reg(2'd2, 32'd4, "R2");
      // R4 write frame at S=2, busy visible (R9), mid-frame write ignored (R3)
      wr(2'd0, CMD_WR);
      bus_addr = 2'd1;
      #3 check(bus_rdata == 32'd1, "R9", "busy after start", bus_rdata, 32'd1);
      repeat (40) @(negedge clk);
      wr(2'd0, 32'h1234_5678);
      repeat (230) @(negedge clk);
      expect_reg(2'd0, CMD_WR, "R3");
      expect_reg(2'd1, EVT, "R7");
      // R8 write-one-to-clear
      wr(2'd1, 32'd0);
      expect_reg(2'd1, EVT, "R8");
      wr(2'd1, EVT);
      expect_reg(2'd1, 32'd0, "R8");
      // R6 read frame at S=1
      wr(2'd2, 32'd1 << 1);
      reply = 16'h8001;
      wr(2'd0, CMD_RD1);
      repeat (140) @(negedge clk);
      expect_reg(2'd0, {CMD_RD1[31:16], 16'h8001}, "R6");
      expect_reg(2'd1, EVT, "R7");
      wr(2'd1, EVT);
      // R6 read frame at S=3
      wr(2'd2, 32'd3 << 1);
      reply = 16'h3C5A;
      wr(2'd0, CMD_RD3);
      repeat (400) @(negedge clk);
      expect_reg(2'd0, {CMD_RD3[31:16], 16'h3C5A}, "R6");
      wr(2'd1, EVT);
      expect_reg(2'd1, 32'd0, "R8");
      // R8 clear on the completion clock: flag must stay set
      wr(2'd2, 32'd1 << 1);
      wr(2'd0, CMD_WR);
      repeat (126) @(negedge clk);
      wr(2'd1, EVT);
      expect_reg(2'd1, EVT, "R8");
      expect_reg(2'd0, CMD_WR, "R4");
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      #(20 * 200000);
      nerr++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule